// File: doc/BRIEF.md
# Fetch-Target to Instruction-Prefetch Shim

This block sits between a branch predictor's fetch-target queue and the instruction cache. Each cycle it may receive one queue entry: a virtual fetch PC, a branch kind, a taken flag and a branch target. When the entry is valid and reports a taken branch, the shim builds a prefetch request. The request carries a physical cache-line address, a small confidence code derived from the branch kind, and the branch target. The request is presented from an output register one cycle later. Address translation is treated as identity, so the line address is the virtual PC with its line-offset bits removed, widened with zeros to the physical line-address width.

A flush input, driven when a branch misprediction resolves, removes any request the shim holds and blocks an entry that arrives in the same cycle. Without a new taken entry, the request valid flag drops on the next clock. The cache therefore sees each request for exactly one cycle.

Top module: `ftq_pf_shim`

## Requirements
- R1: A synchronous active-high reset `rst` drives `pf_valid_o` low at the clock edge where it is sampled, whatever the other inputs are.
- R2: `pf_line_o` equals the fetch PC bits 38 down to 6, placed in bits 32:0, with bits 39:33 zero. The PC is 39 bits wide and the cache line is 64 bytes.
- R3: `pf_conf_o` is derived from the branch kind with this encoding: `2'b00` no branch gives 0, `2'b01` conditional gives 4, `2'b10` call gives 5, `2'b11` return gives 6.
- R4: `pf_target_o` is the entry's 39-bit branch target, unchanged.
- R5: If an entry has `ent_valid_i` and `ent_taken_i` high and `flush_i` low at a clock edge, `pf_valid_o` is high after that edge. Its payload comes from that entry.
- R6: If an edge has `ent_valid_i` low or `ent_taken_i` low, `pf_valid_o` is low after that edge, even if a request was shown in the previous cycle.
- R7: `flush_i` high at an edge drives `pf_valid_o` low after that edge. It takes priority over a valid taken entry in the same cycle, and it clears a request that was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ent_valid_i | input | 1 | Queue entry present |
| ent_pc_i | input | 39 | Virtual fetch PC of the entry |
| ent_kind_i | input | 2 | Branch kind (00 none, 01 cond, 10 call, 11 return) |
| ent_taken_i | input | 1 | Entry reports a taken branch |
| ent_target_i | input | 39 | Branch target of the entry |
| flush_i | input | 1 | Misprediction flush |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_line_o | output | 40 | Physical line address |
| pf_conf_o | output | 3 | Prefetch confidence |
| pf_target_o | output | 39 | Branch target carried with the request |

## Verification
The hardest case to reach is a flush that lands on the same edge as a valid taken entry while an earlier request is still being shown. In that case both the pending request and the newcomer must disappear together. Random stimulus drives flush at a moderate rate against a high rate of taken entries, so this overlap occurs many times. Directed sequences also set it up on purpose: they show a request first, then flush on the next edge with a fresh taken entry present. Further directed vectors cover the extreme PCs, all four branch kinds, and a reset that arrives together with a firing entry.

// File: rtl/ftq_pf_pkg.sv
package ftq_pf_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_COND = 2'b01,
    BK_CALL = 2'b10,
    BK_RET  = 2'b11
  } br_kind_e;

  localparam int unsigned DEF_VA_W     = 39;
  localparam int unsigned DEF_LINE_W   = 40;
  localparam int unsigned DEF_LINE_OFF = 6;
  localparam int unsigned DEF_CONF_W   = 3;

endpackage

// File: rtl/ftq_pf_line_addr.sv
module ftq_pf_line_addr #(
  parameter int unsigned VA_W     = 39,
  parameter int unsigned LINE_OFF = 6,
  parameter int unsigned LINE_W   = 40
) (
  input  logic [VA_W-1:0]   pc_i,
  output logic [LINE_W-1:0] line_o
);
  localparam int unsigned KEEP_W = VA_W - LINE_OFF;

  generate
    if (LINE_W > KEEP_W) begin : g_zext
      assign line_o = {{(LINE_W-KEEP_W){1'b0}}, pc_i[VA_W-1:LINE_OFF]};
    end else begin : g_trunc
      assign line_o = pc_i[LINE_OFF+LINE_W-1:LINE_OFF];
    end
  endgenerate
endmodule

// File: rtl/ftq_pf_conf_enc.sv
module ftq_pf_conf_enc
  import ftq_pf_pkg::*;
#(
  parameter int unsigned CONF_W = 3
) (
  input  br_kind_e          kind_i,
  output logic [CONF_W-1:0] conf_o
);
  always_comb begin
    unique case (kind_i)
      BK_COND: conf_o = CONF_W'(4);
      BK_CALL: conf_o = CONF_W'(5);
      BK_RET:  conf_o = CONF_W'(6);
      default: conf_o = '0;
    endcase
  end
endmodule

// File: rtl/ftq_pf_out_reg.sv
module ftq_pf_out_reg #(
  parameter int unsigned W = 82
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= load_i & ~flush_i;
  end

  always_ff @(posedge clk) begin
    if (load_i && !flush_i) data_q <= data_i;
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !valid_o);
  a_r7_flush_wins: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !valid_o);
  a_r5_hold_payload: assert property (@(posedge clk) disable iff (rst)
    (load_i && !flush_i) |=> (valid_o && data_o == $past(data_i)));
endmodule

// File: rtl/ftq_pf_shim.sv
module ftq_pf_shim
  import ftq_pf_pkg::*;
#(
  parameter int unsigned VA_W     = DEF_VA_W,
  parameter int unsigned LINE_W   = DEF_LINE_W,
  parameter int unsigned LINE_OFF = DEF_LINE_OFF,
  parameter int unsigned CONF_W   = DEF_CONF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ent_valid_i,
  input  logic [VA_W-1:0]   ent_pc_i,
  input  logic [1:0]        ent_kind_i,
  input  logic              ent_taken_i,
  input  logic [VA_W-1:0]   ent_target_i,
  input  logic              flush_i,
  output logic              pf_valid_o,
  output logic [LINE_W-1:0] pf_line_o,
  output logic [CONF_W-1:0] pf_conf_o,
  output logic [VA_W-1:0]   pf_target_o
);
  localparam int unsigned PKT_W = LINE_W + CONF_W + VA_W;

  logic [LINE_W-1:0] line_d;
  logic [CONF_W-1:0] conf_d;
  logic [PKT_W-1:0]  pkt_d, pkt_q;
  logic              fire;

  ftq_pf_line_addr #(.VA_W(VA_W), .LINE_OFF(LINE_OFF), .LINE_W(LINE_W)) u_line (
    .pc_i   (ent_pc_i),
    .line_o (line_d)
  );

  ftq_pf_conf_enc #(.CONF_W(CONF_W)) u_conf (
    .kind_i (br_kind_e'(ent_kind_i)),
    .conf_o (conf_d)
  );

  assign fire  = ent_valid_i & ent_taken_i;
  assign pkt_d = {line_d, conf_d, ent_target_i};

  ftq_pf_out_reg #(.W(PKT_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .flush_i (flush_i),
    .load_i  (fire),
    .data_i  (pkt_d),
    .valid_o (pf_valid_o),
    .data_o  (pkt_q)
  );

  assign pf_line_o   = pkt_q[PKT_W-1 -: LINE_W];
  assign pf_conf_o   = pkt_q[VA_W +: CONF_W];
  assign pf_target_o = pkt_q[VA_W-1:0];

  a_r6_no_taken_no_req: assert property (@(posedge clk) disable iff (rst)
    !(ent_valid_i && ent_taken_i) |=> !pf_valid_o);
  a_r2_line_from_pc: assert property (@(posedge clk) disable iff (rst)
    (ent_valid_i && ent_taken_i && !flush_i) |=>
      (pf_line_o[LINE_W-1:VA_W-LINE_OFF] == '0 &&
       pf_line_o[VA_W-LINE_OFF-1:0] == $past(ent_pc_i[VA_W-1:LINE_OFF])));
  a_r3_conf_legal: assert property (@(posedge clk) disable iff (rst)
    pf_valid_o |-> (pf_conf_o == 0 || pf_conf_o == 4 || pf_conf_o == 5 || pf_conf_o == 6));
  a_r4_target_kept: assert property (@(posedge clk) disable iff (rst)
    (ent_valid_i && ent_taken_i && !flush_i) |=> pf_target_o == $past(ent_target_i));
endmodule

// File: tb/ftq_pf_shim_bench.sv
module ftq_pf_shim_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        ent_valid_i, ent_taken_i, flush_i;
  logic [38:0] ent_pc_i, ent_target_i;
  logic [1:0]  ent_kind_i;
  logic        pf_valid_o;
  logic [39:0] pf_line_o;
  logic [2:0]  pf_conf_o;
  logic [38:0] pf_target_o;

  int unsigned n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  logic        e_valid;
  logic [39:0] e_line;
  logic [2:0]  e_conf;
  logic [38:0] e_tgt;

  always #2 clk = ~clk;

  ftq_pf_shim u_ftq_pf_shim (
    .clk(clk), .rst(rst), .ent_valid_i(ent_valid_i), .ent_pc_i(ent_pc_i),
    .ent_kind_i(ent_kind_i), .ent_taken_i(ent_taken_i), .ent_target_i(ent_target_i),
    .flush_i(flush_i), .pf_valid_o(pf_valid_o), .pf_line_o(pf_line_o),
    .pf_conf_o(pf_conf_o), .pf_target_o(pf_target_o)
  );

  function automatic logic [39:0] exp_line(logic [38:0] pc);
    return {7'd0, pc[38:6]};
  endfunction

  function automatic logic [2:0] exp_conf(logic [1:0] k);
    case (k)
      2'b01: return 3'd4;
      2'b10: return 3'd5;
      2'b11: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic r, logic v, logic [38:0] pc, logic [1:0] k,
                      logic t, logic [38:0] tg, logic f);
    @(negedge clk);
    rst = r; ent_valid_i = v; ent_pc_i = pc; ent_kind_i = k;
    ent_taken_i = t; ent_target_i = tg; flush_i = f;
    if (r) e_valid = 1'b0;
    else if (v && t && !f) begin
      e_valid = 1'b1; e_line = exp_line(pc); e_conf = exp_conf(k); e_tgt = tg;
    end else e_valid = 1'b0;
    @(posedge clk); #1;
    if (r) check("R1 reset valid", 64'(pf_valid_o), 64'(1'b0));
    else if (f) check("R7 flush valid", 64'(pf_valid_o), 64'(e_valid));
    else if (!(v && t)) check("R6 idle valid", 64'(pf_valid_o), 64'(e_valid));
    else check("R5 fire valid", 64'(pf_valid_o), 64'(e_valid));
    if (e_valid && pf_valid_o) begin
      check("R2 line", 64'(pf_line_o), 64'(e_line));
      check("R3 conf", 64'(pf_conf_o), 64'(e_conf));
      check("R4 target", 64'(pf_target_o), 64'(e_tgt));
    end
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    void'($urandom(32'h1f2e3d4c));
    rst = 1'b1; ent_valid_i = 0; ent_taken_i = 0; flush_i = 0;
    ent_pc_i = '0; ent_target_i = '0; ent_kind_i = '0;
    e_valid = 0; e_line = '0; e_conf = '0; e_tgt = '0;
    step(1, 0, 39'd0, 2'b00, 0, 39'd0, 0);
    step(1, 0, 39'd0, 2'b00, 0, 39'd0, 0);
    // R1: reset while an entry would fire
    step(0, 1, 39'h12_3456_7890, 2'b01, 1, 39'h55, 0);
    step(1, 1, 39'h12_3456_7890, 2'b01, 1, 39'h55, 0);
    // R2 extremes, R3 every kind
    step(0, 1, {39{1'b1}}, 2'b00, 1, {39{1'b1}}, 0);
    step(0, 1, 39'h3f, 2'b01, 1, 39'd0, 0);
    step(0, 1, 39'h40, 2'b10, 1, 39'h7f_ffff_0000, 0);
    step(0, 1, 39'h40_0000_0000, 2'b11, 1, 39'h1, 0);
    // R6: not taken, then not valid, after a shown request
    step(0, 1, 39'h1000, 2'b10, 0, 39'h2, 0);
    step(0, 1, 39'h2000, 2'b01, 1, 39'h3, 0);
    step(0, 0, 39'h3000, 2'b01, 1, 39'h4, 0);
    // R7: flush over a pending request and a new taken entry
    step(0, 1, 39'h4000, 2'b11, 1, 39'h5, 0);
    step(0, 1, 39'h5000, 2'b10, 1, 39'h6, 1);
    step(0, 1, 39'h6000, 2'b01, 1, 39'h7, 0);
    step(0, 0, 39'h0, 2'b00, 0, 39'h0, 1);
    for (int i = 0; i < 400; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      step(($urandom % 50) == 0, ($urandom % 8) != 0, ra[38:0], 2'($urandom),
           ($urandom % 4) != 0, rb[38:0], ($urandom % 5) == 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule